// File: doc/BRIEF.md
# Synchronous Burst SRAM Front End

This block is a clocked single-port memory with a burst address counter. Its array is organised as two byte lanes of nine bits each: eight data bits plus one parity bit. On every rising clock edge it samples three chip selects, two address strobes, a burst-advance input, the write controls and a sleep input. From these it decides to deselect, start a read, start a write, continue a burst at the next address, or hold a burst at its current address. Read data is flow-through. After the edge that registers an address, the array word at that address appears on `dq_o`, and it is valid before the following edge.

One of the address strobes belongs to the processor side and the other to the controller side. A processor-strobe cycle always starts a read, whatever the write inputs say. The processor strobe counts only while `sel1_ni` is low. A controller-strobe cycle can start either a read or a write. Once an access has been started, cycles with no effective strobe carry the burst forward. The burst counter wraps within an aligned group of four words and leaves the upper address bits unchanged. The output enable acts on the bus-drive control without reference to the clock.

Top module: `sync_burst_sram`

## Requirements
- R1: The write request is active when `wr_all_ni` is low, or when `wr_byte_ni` is low and at least one bit of `lane_wr_ni` is low. With `wr_all_ni` low, both lanes are written. Otherwise, with `wr_byte_ni` low, a write updates only the lanes whose `lane_wr_ni` bit is low. Lane 0 is `dq` bits [8:0] and lane 1 is bits [17:9]. With `wr_byte_ni` low and both select bits high, the cycle is a read.
- R2: When the processor strobe is effective (`cpu_stb_ni` low and `sel1_ni` low) and the chip is selected (`sel1_ni` low, `sel2_i` high, `sel3_ni` low), the block loads `addr_i` and performs a read, even if the write request is active. The word at that address appears on `dq_o` after that edge.
- R3: When `ctl_stb_ni` is low, the processor strobe is not effective, and the chip is selected, the block loads `addr_i`. If the write request is active, `dq_i` is written there on that edge according to R1. Otherwise the cycle is a read.
- R4: An effective strobe with the chip not selected deselects the block. This covers `sel1_ni` high with `ctl_stb_ni` low, and `sel1_ni` low with `sel2_i` low or `sel3_ni` high. After a deselect the bus is released, and later cycles with no strobe perform no access until a new strobe starts one.
- R5: While `sel1_ni` is high, a low `cpu_stb_ni` has no effect. With `ctl_stb_ni` high, such a cycle behaves as a burst cycle.
- R6: In a cycle with no effective strobe during an active access, `adv_ni` low moves to the next burst address. The two low address bits increment and wrap from 3 to 0, and the upper bits stay fixed. If the write request is active, that next address is written.
- R7: In a cycle with no effective strobe during an active access, `adv_ni` high keeps the current address. A read repeats that word, and an active write request writes it.
- R8: `dq_oe_o` is high exactly when the last registered cycle was a read, `oe_ni` is low and `sleep_i` is low. It follows `oe_ni` without waiting for a clock edge. After a write cycle it is low.
- R9: A cycle with `sleep_i` high performs no read or write, ends any active access and releases the bus.
- R10: After reset, the bus is released, no access is active and every array word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Sleep; overrides every other control |
| sel1_ni | input | 1 | Chip select 1, active low; also qualifies the processor strobe |
| sel2_i | input | 1 | Chip select 2, active high |
| sel3_ni | input | 1 | Chip select 3, active low |
| cpu_stb_ni | input | 1 | Processor address strobe, active low; always starts a read |
| ctl_stb_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| wr_all_ni | input | 1 | Global write of all lanes, active low |
| wr_byte_ni | input | 1 | Byte-write enable, active low |
| lane_wr_ni | input | LANES | Per-lane write selects, active low |
| oe_ni | input | 1 | Output enable, active low, not clocked |
| addr_i | input | ADDR_W | External address |
| dq_i | input | LANES*LANE_W | Write data |
| dq_o | output | LANES*LANE_W | Read data |
| dq_oe_o | output | 1 | Bus drive enable; low means the bus is released |

## Verification
The bound assertions are checked on every cycle. They cover these properties:
- a processor-strobe read drives the bus on the next cycle whenever `oe_ni` is low;
- a controller-strobe write leaves the bus released;
- every deselecting cycle and every sleep cycle releases the bus;
- a suspend cycle with no write leaves `dq_o` unchanged.

Other properties need the bench's directed scenarios, with a reference array compared on every clock. These are the lane masking of partial writes and the wrap of the burst counter at a four-word boundary. They also include the writes that carry on after a processor-strobe read and the cleared array after reset.

// File: rtl/sync_burst_sram_pkg.sv
`timescale 1ns/1ps
package sync_burst_sram_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_DESEL = 2'd1,
    OP_START = 2'd2,
    OP_STEP  = 2'd3
  } bus_op_e;
endpackage

// File: rtl/sync_burst_sram_decode.sv
`timescale 1ns/1ps
module sync_burst_sram_decode
  import sync_burst_sram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             sleep_i,
  input  logic             sel1_ni,
  input  logic             sel2_i,
  input  logic             sel3_ni,
  input  logic             cpu_stb_ni,
  input  logic             ctl_stb_ni,
  input  logic             wr_all_ni,
  input  logic             wr_byte_ni,
  input  logic [LANES-1:0] lane_wr_ni,
  input  logic             active_i,
  output bus_op_e          op_o,
  output logic             wr_o,
  output logic [LANES-1:0] lane_we_o
);
  logic             selected;
  logic             cpu_eff;
  logic             wr_req;
  logic [LANES-1:0] lane_mask;

  assign selected = ~sel1_ni & sel2_i & ~sel3_ni;
  assign cpu_eff  = ~cpu_stb_ni & ~sel1_ni;
  assign wr_req   = ~wr_all_ni | (~wr_byte_ni & (|(~lane_wr_ni)));

  always_comb begin
    if (!wr_all_ni)       lane_mask = '1;
    else if (!wr_byte_ni) lane_mask = ~lane_wr_ni;
    else                  lane_mask = '0;
  end

  always_comb begin
    op_o = OP_HOLD;
    wr_o = 1'b0;
    if (sleep_i) begin
      op_o = OP_DESEL;
    end else if (cpu_eff || !ctl_stb_ni) begin
      if (!selected) begin
        op_o = OP_DESEL;
      end else begin
        op_o = OP_START;
        wr_o = ~cpu_eff & wr_req;  // processor strobe forces a read
      end
    end else if (active_i) begin
      op_o = OP_STEP;
      wr_o = wr_req;
    end
  end

  assign lane_we_o = wr_o ? lane_mask : '0;
endmodule

// File: rtl/sync_burst_sram_burst.sv
`timescale 1ns/1ps
module sync_burst_sram_burst
  import sync_burst_sram_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_op_e           op_i,
  input  logic              adv_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] tgt_o,
  output logic [ADDR_W-1:0] addr_q_o
);
  logic [ADDR_W-1:0]  addr_q;
  logic [ADDR_W-1:0]  addr_nxt;
  logic [BURST_W-1:0] cnt_inc;

  assign cnt_inc  = addr_q[BURST_W-1:0] + 1'b1;
  assign addr_nxt = {addr_q[ADDR_W-1:BURST_W], cnt_inc};

  always_comb begin
    if (op_i == OP_START) tgt_o = addr_i;
    else if (!adv_ni)     tgt_o = addr_nxt;
    else                  tgt_o = addr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  addr_q <= '0;
    else if (op_i == OP_START || op_i == OP_STEP) addr_q <= tgt_o;
  end

  assign addr_q_o = addr_q;
endmodule

// File: rtl/sync_burst_sram_array.sv
`timescale 1ns/1ps
module sync_burst_sram_array #(
  parameter int ADDR_W = 5,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DW-1:0]     rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we_i[l]) begin
        mem[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
      end
    end

    assign rdata_o[l*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram
  import sync_burst_sram_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic              sel1_ni,
  input  logic              sel2_i,
  input  logic              sel3_ni,
  input  logic              cpu_stb_ni,
  input  logic              ctl_stb_ni,
  input  logic              adv_ni,
  input  logic              wr_all_ni,
  input  logic              wr_byte_ni,
  input  logic [LANES-1:0]  lane_wr_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     dq_i,
  output logic [DW-1:0]     dq_o,
  output logic              dq_oe_o
);
  bus_op_e           op;
  logic              wr;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] tgt;
  logic [ADDR_W-1:0] addr_q;
  logic              active_q;
  logic              rd_q;

  sync_burst_sram_decode #(.LANES(LANES)) u_decode (
    .sleep_i    (sleep_i),
    .sel1_ni    (sel1_ni),
    .sel2_i     (sel2_i),
    .sel3_ni    (sel3_ni),
    .cpu_stb_ni (cpu_stb_ni),
    .ctl_stb_ni (ctl_stb_ni),
    .wr_all_ni  (wr_all_ni),
    .wr_byte_ni (wr_byte_ni),
    .lane_wr_ni (lane_wr_ni),
    .active_i   (active_q),
    .op_o       (op),
    .wr_o       (wr),
    .lane_we_o  (lane_we)
  );

  sync_burst_sram_burst #(.ADDR_W(ADDR_W), .BURST_W(2)) u_burst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .adv_ni   (adv_ni),
    .addr_i   (addr_i),
    .tgt_o    (tgt),
    .addr_q_o (addr_q)
  );

  sync_burst_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (lane_we),
    .waddr_i (tgt),
    .wdata_i (dq_i),
    .raddr_i (addr_q),
    .rdata_o (dq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
    end else begin
      unique case (op)
        OP_DESEL: begin
          active_q <= 1'b0;
          rd_q     <= 1'b0;
        end
        OP_START: begin
          active_q <= 1'b1;
          rd_q     <= ~wr;
        end
        OP_STEP:  rd_q <= ~wr;
        default:  ;
      endcase
    end
  end

  // output enable is not clocked; writes mask it through rd_q
  assign dq_oe_o = rd_q & ~oe_ni & ~sleep_i;
endmodule

// File: rtl/sync_burst_sram_chk.sv
`timescale 1ns/1ps
module sync_burst_sram_chk #(
  parameter int ADDR_W = 5,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    sleep_i,
  input logic                    sel1_ni,
  input logic                    sel2_i,
  input logic                    sel3_ni,
  input logic                    cpu_stb_ni,
  input logic                    ctl_stb_ni,
  input logic                    adv_ni,
  input logic                    wr_all_ni,
  input logic                    wr_byte_ni,
  input logic [LANES-1:0]        lane_wr_ni,
  input logic                    oe_ni,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [LANES*LANE_W-1:0] dq_i,
  input logic [LANES*LANE_W-1:0] dq_o,
  input logic                    dq_oe_o
);
  logic sel_ok;
  logic no_stb;
  logic no_wr;

  assign sel_ok = ~sel1_ni & sel2_i & ~sel3_ni;
  assign no_stb = ctl_stb_ni & (cpu_stb_ni | sel1_ni);
  assign no_wr  = wr_all_ni & (wr_byte_ni | (&lane_wr_ni));

  a_r2_cpu_read_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && sel_ok && !cpu_stb_ni) |=> (dq_oe_o || oe_ni || sleep_i));

  a_r3_ctl_write_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && sel_ok && cpu_stb_ni && !ctl_stb_ni && !wr_all_ni) |=> !dq_oe_o);

  a_r4_desel_low_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !sel1_ni && (!sel2_i || sel3_ni) && (!cpu_stb_ni || !ctl_stb_ni))
    |=> !dq_oe_o);

  a_r4_desel_sel1_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && sel1_ni && !ctl_stb_ni) |=> !dq_oe_o);

  a_r7_suspend_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && no_stb && adv_ni && no_wr) |=> $stable(dq_o));

  a_r9_sleep_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !dq_oe_o);
endmodule

bind sync_burst_sram sync_burst_sram_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
) u_chk (.*);

// File: tb/sync_burst_sram_bench.sv
`timescale 1ns/1ps
module sync_burst_sram_bench;
  localparam int AW = 5;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep, sel1_n, sel2, sel3_n, cpu_n, ctl_n, adv_n, wall_n, wbyte_n, oe_n;
  logic [1:0]    lane_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dq_o;
  logic          dq_oe;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [DW-1:0] m_mem [32];
  logic [AW-1:0] m_addr;
  bit            m_act, m_rd;

  always #2 clk = ~clk;

  sync_burst_sram u_sync_burst_sram (
    .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep), .sel1_ni(sel1_n), .sel2_i(sel2),
    .sel3_ni(sel3_n), .cpu_stb_ni(cpu_n), .ctl_stb_ni(ctl_n), .adv_ni(adv_n),
    .wr_all_ni(wall_n), .wr_byte_ni(wbyte_n), .lane_wr_ni(lane_n), .oe_ni(oe_n),
    .addr_i(addr), .dq_i(din), .dq_o(dq_o), .dq_oe_o(dq_oe)
  );

  function automatic logic [DW-1:0] pat(input int i);
    return 18'h2AA00 ^ 18'(i * 37);
  endfunction

  task automatic idle();
    sleep = 0; sel1_n = 1; sel2 = 1; sel3_n = 0; cpu_n = 1; ctl_n = 1;
    adv_n = 1; wall_n = 1; wbyte_n = 1; lane_n = 2'b11; oe_n = 0;
  endtask

  task automatic write_lanes(input logic [AW-1:0] a, input logic [1:0] mask, input logic [DW-1:0] d);
    if (mask[0]) m_mem[a][8:0]  = d[8:0];
    if (mask[1]) m_mem[a][17:9] = d[17:9];
  endtask

  // behavioural reference, evaluated on each rising edge
  task automatic model_step();
    bit wreq;
    logic [1:0] mask;
    logic [AW-1:0] t;
    wreq = !wall_n || (!wbyte_n && lane_n != 2'b11);
    mask = !wall_n ? 2'b11 : (!wbyte_n ? ~lane_n : 2'b00);
    if (sleep) begin
      m_act = 0; m_rd = 0;
    end else if ((!cpu_n && !sel1_n) || !ctl_n) begin
      if (sel1_n || !sel2 || sel3_n) begin
        m_act = 0; m_rd = 0;
      end else begin
        m_addr = addr; m_act = 1;
        if (!cpu_n) m_rd = 1;
        else begin
          m_rd = !wreq;
          if (wreq) write_lanes(addr, mask, din);
        end
      end
    end else if (m_act) begin
      t = m_addr;
      if (!adv_n) t[1:0] = t[1:0] + 2'd1;
      if (wreq) write_lanes(t, mask, din);
      m_rd = !wreq;
      m_addr = t;
    end
  endtask

  task automatic compare(input string tag);
    bit exp_oe;
    exp_oe = m_rd && !oe_n && !sleep;
    compared++;
    if (dq_oe !== exp_oe) begin
      mismatched++;
      $display("FAIL %s dq_oe_o actual=%b expected=%b", tag, dq_oe, exp_oe);
    end
    if (m_rd) begin
      compared++;
      if (dq_o !== m_mem[m_addr]) begin
        mismatched++;
        $display("FAIL %s dq_o actual=%h expected=%h", tag, dq_o, m_mem[m_addr]);
      end
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_step();
    #1;
    compare(tag);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic ctl_go(input logic [AW-1:0] a, input bit wr, input logic [DW-1:0] d, input string tag);
    idle(); sel1_n = 0; ctl_n = 0; addr = a; din = d; wall_n = !wr;
    tick(tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle(); addr = '0; din = '0;
    for (int i = 0; i < 32; i++) m_mem[i] = '0;
    m_addr = '0; m_act = 0; m_rd = 0;
    repeat (3) @(negedge clk);
    chk("R10 bus released in reset", {17'd0, dq_oe}, 18'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 bus released after reset", {17'd0, dq_oe}, 18'd0);
    ctl_go(5'd3, 0, '0, "R10");
    chk("R10 cleared word", dq_o, 18'd0);

    // R3: controller-strobe writes
    for (int i = 4; i < 8; i++) ctl_go(5'(i), 1, pat(i), "R3");
    chk("R3 write masks bus", {17'd0, dq_oe}, 18'd0);

    // R2: processor strobe with write inputs active still reads
    idle(); sel1_n = 0; cpu_n = 0; addr = 5'd5; wall_n = 0; din = 18'h3FFFF;
    tick("R2");
    chk("R2 read data", dq_o, pat(5));
    chk("R2 bus driven", {17'd0, dq_oe}, 18'd1);

    // R6: burst wraps 6,7,4
    idle(); sel1_n = 0; adv_n = 0;
    tick("R6"); chk("R6 next 6", dq_o, pat(6));
    tick("R6"); chk("R6 next 7", dq_o, pat(7));
    tick("R6"); chk("R6 wrap 4", dq_o, pat(4));

    // R7: suspend
    adv_n = 1;
    tick("R7"); chk("R7 hold 4", dq_o, pat(4));

    // R8: asynchronous output enable
    oe_n = 1; #0.5;
    chk("R8 oe high releases", {17'd0, dq_oe}, 18'd0);
    oe_n = 0; #0.5;
    chk("R8 oe low drives", {17'd0, dq_oe}, 18'd1);

    // R5: processor strobe ignored while sel1 high -> burst continues
    idle(); sel1_n = 1; cpu_n = 0; adv_n = 0;
    tick("R5"); chk("R5 continued to 5", dq_o, pat(5));

    // R1: lane masking
    ctl_go(5'd9, 1, 18'h3FFFF, "R1");
    idle(); sel1_n = 0; ctl_n = 0; addr = 5'd9; wbyte_n = 0; lane_n = 2'b10; din = '0;
    tick("R1");
    ctl_go(5'd9, 0, '0, "R1");
    chk("R1 lane0 written only", dq_o, 18'h3FE00);
    idle(); sel1_n = 0; ctl_n = 0; addr = 5'd9; wbyte_n = 0; lane_n = 2'b11; din = '0;
    tick("R1");
    chk("R1 no lane selected reads", {17'd0, dq_oe}, 18'd1);
    chk("R1 no lane selected data", dq_o, 18'h3FE00);
    idle(); sel1_n = 0; ctl_n = 0; addr = 5'd9; wbyte_n = 0; lane_n = 2'b01; din = 18'h00000;
    tick("R1");
    ctl_go(5'd9, 0, '0, "R1");
    chk("R1 lane1 written", dq_o, 18'h00000);

    // writes after a processor-strobe read
    idle(); sel1_n = 0; cpu_n = 0; addr = 5'd12;
    tick("R2");
    idle(); wall_n = 0; din = 18'h12345;
    tick("R7");
    chk("R8 write cycle masks bus", {17'd0, dq_oe}, 18'd0);
    adv_n = 0; din = 18'h0ABCD;
    tick("R6");
    ctl_go(5'd12, 0, '0, "R7");
    chk("R7 current-address write", dq_o, 18'h12345);
    idle(); adv_n = 0;
    tick("R6");
    chk("R6 next-address write", dq_o, 18'h0ABCD);

    // R4: deselect
    idle(); sel1_n = 0; sel2 = 0; ctl_n = 0; addr = 5'd4;
    tick("R4");
    chk("R4 sel2 low releases", {17'd0, dq_oe}, 18'd0);
    idle(); adv_n = 0; wall_n = 0; din = 18'h3FFFF;
    tick("R4");
    ctl_go(5'd12, 0, '0, "R4");
    chk("R4 no access after deselect", dq_o, 18'h12345);
    idle(); sel1_n = 1; ctl_n = 0;
    tick("R4");
    chk("R4 sel1 high releases", {17'd0, dq_oe}, 18'd0);
    idle(); sel1_n = 0; cpu_n = 0; sel3_n = 1;
    tick("R4");

    // R9: sleep
    ctl_go(5'd4, 0, '0, "R9");
    idle(); sleep = 1;
    tick("R9");
    chk("R9 sleep releases", {17'd0, dq_oe}, 18'd0);
    idle(); sleep = 1; sel1_n = 0; ctl_n = 0; addr = 5'd20; wall_n = 0; din = 18'h3FFFF;
    tick("R9");
    ctl_go(5'd20, 0, '0, "R9");
    chk("R9 no write in sleep", dq_o, 18'd0);

    // mixed random traffic against the reference
    for (int n = 0; n < 600; n++) begin
      sleep   = ($urandom_range(0, 19) == 0);
      sel1_n  = ($urandom_range(0, 4) == 0);
      sel2    = ($urandom_range(0, 9) != 0);
      sel3_n  = ($urandom_range(0, 9) == 0);
      cpu_n   = ($urandom_range(0, 5) != 0);
      ctl_n   = ($urandom_range(0, 4) != 0);
      adv_n   = 1'($urandom);
      wall_n  = ($urandom_range(0, 4) != 0);
      wbyte_n = 1'($urandom);
      lane_n  = 2'($urandom);
      oe_n    = ($urandom_range(0, 5) == 0);
      addr    = AW'($urandom);
      din     = DW'($urandom);
      tick("R6 mixed");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule